// File: doc/BRIEF.md
# Three-Entry Register Stack

This block holds one processor register as a small stack of three 16-bit entries: top, next and bottom. The core keeps one instance each for its accumulator and its two index registers. Ordinary loads write the top entry only. No load pushes the stack, so code written for a flat register file runs unchanged. A store reads the top output, and no store can disturb the stack.

Explicit stack operations reshape the three entries. Dup copies the top downward. Swap exchanges the top two entries. Rotate moves every entry up one place, and the old top wraps to the bottom. Two data operations rewrite the top alone: one exchanges its two bytes and one mirrors its bit order. A size flag selects byte loads, which clear the upper byte of the top entry.

Top module: `reg_stack3`

## Requirements
- R1: While `rst_n` is low, all three entries read zero.
- R2: A load with `byte_mode`=0 sets `tos` to `ld_data` one clock later. `nos` and `bos` are unchanged.
- R3: A load with `byte_mode`=1 sets `tos` to {8'h00, `ld_data[7:0]`}. `nos` and `bos` are unchanged.
- R4: When `ld_en` is 1, the load is applied and `op` is ignored.
- R5: `op`=1 (dup) sets {tos,nos,bos} to {tos,tos,nos}.
- R6: `op`=2 (swap) sets {tos,nos,bos} to {nos,tos,bos}.
- R7: `op`=3 (rotate) sets {tos,nos,bos} to {nos,bos,tos}.
- R8: `op`=4 (byte swap) sets `tos` to {tos[7:0], tos[15:8]}. `nos` and `bos` are unchanged.
- R9: `op`=5 (bit reverse) sets `tos` bit i to the old `tos` bit 15-i. `nos` and `bos` are unchanged.
- R10: With no load, `op` values 0, 6 and 7 leave all three entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Stack or data operation select |
| ld_en | input | 1 | Load the top entry |
| ld_data | input | 16 | Load value |
| byte_mode | input | 1 | 1 selects a byte load |
| tos | output | 16 | Top entry |
| nos | output | 16 | Next entry |
| bos | output | 16 | Bottom entry |

## Verification
Every load and every operation takes effect at the first rising edge after it is presented, so each result is due exactly one cycle after its stimulus. The bench drives inputs on the falling edge. It compares all three outputs on the following falling edge, after the single register stage has updated and before the next stimulus is driven. During reset the outputs are checked with no edge counting, because the reset is asynchronous.

// File: rtl/reg_stack3.sv
module reg_stack3 #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic             ld_en,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             byte_mode,
  output logic [WIDTH-1:0] tos,
  output logic [WIDTH-1:0] nos,
  output logic [WIDTH-1:0] bos
);
  localparam int HALF = WIDTH / 2;

  localparam logic [2:0] OP_DUP  = 3'd1;
  localparam logic [2:0] OP_SWAP = 3'd2;
  localparam logic [2:0] OP_ROT  = 3'd3;
  localparam logic [2:0] OP_BSWP = 3'd4;
  localparam logic [2:0] OP_BREV = 3'd5;

  logic [WIDTH-1:0] rev_tos;
  logic [WIDTH-1:0] ld_val;
  logic [WIDTH-1:0] t_n, n_n, b_n;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) rev_tos[i] = tos[WIDTH-1-i];
  end

  assign ld_val = byte_mode ? {{HALF{1'b0}}, ld_data[HALF-1:0]} : ld_data;

  always_comb begin
    t_n = tos;
    n_n = nos;
    b_n = bos;
    if (ld_en) t_n = ld_val;
    else begin
      case (op)
        OP_DUP:  begin n_n = tos; b_n = nos; end
        OP_SWAP: begin t_n = nos; n_n = tos; end
        OP_ROT:  begin t_n = nos; n_n = bos; b_n = tos; end
        OP_BSWP: t_n = {tos[HALF-1:0], tos[WIDTH-1:HALF]};
        OP_BREV: t_n = rev_tos;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos <= '0;
      nos <= '0;
      bos <= '0;
    end else begin
      tos <= t_n;
      nos <= n_n;
      bos <= b_n;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (tos == '0 && nos == '0 && bos == '0));

  a_r2_word_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !byte_mode) |=> (tos == $past(ld_data) && $stable(nos) && $stable(bos)));

  a_r3_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && byte_mode) |=> (tos[WIDTH-1:HALF] == '0 &&
                              tos[HALF-1:0] == $past(ld_data[HALF-1:0]) && $stable(nos)));

  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op != 3'd0) |=> ($stable(nos) && $stable(bos)));

  a_r5_dup: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op == OP_DUP) |=> (tos == $past(tos) && nos == $past(tos) && bos == $past(nos)));

  a_r6_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op == OP_SWAP) |=> (tos == $past(nos) && nos == $past(tos) && $stable(bos)));

  a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op == OP_ROT) |=> (tos == $past(nos) && nos == $past(bos) && bos == $past(tos)));

  a_r8_byte_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op == OP_BSWP) |=> (tos[HALF-1:0] == $past(tos[WIDTH-1:HALF]) &&
                                   tos[WIDTH-1:HALF] == $past(tos[HALF-1:0]) && $stable(nos)));

  a_r9_bit_rev_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op == OP_BREV) |=> (tos[0] == $past(tos[WIDTH-1]) &&
                                   tos[WIDTH-1] == $past(tos[0]) && $stable(bos)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && (op == 3'd0 || op > OP_BREV)) |=> ($stable(tos) && $stable(nos) && $stable(bos)));
endmodule

// File: tb/reg_stack3_test.sv
module reg_stack3_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_data = 16'h0;
  logic        byte_mode = 1'b0;
  logic [15:0] tos, nos, bos;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_t, m_n, m_b;

  reg_stack3 #(.WIDTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .ld_en(ld_en), .ld_data(ld_data),
    .byte_mode(byte_mode), .tos(tos), .nos(nos), .bos(bos)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] at, an, ab,
                     input logic [15:0] et, en, eb);
    checks++;
    if (at !== et || an !== en || ab !== eb) begin
      errors++;
      $display("FAIL %s: got %h %h %h expected %h %h %h", tag, at, an, ab, et, en, eb);
    end
  endtask

  function automatic logic [15:0] mirror(input logic [15:0] v);
    logic [15:0] r = 16'h0;
    for (int i = 0; i < 16; i++) if (v[i]) r = r | (16'h8000 >> i);
    return r;
  endfunction

  task automatic step(input logic l, input logic bm, input logic [2:0] o,
                      input logic [15:0] d);
    logic [15:0] t, n, b;
    string tag;
    t = m_t; n = m_n; b = m_b;
    if (l) begin
      t = bm ? (d % 16'h0100) : d;
      if (o != 3'd0) tag = "R4";
      else tag = bm ? "R3" : "R2";
    end else begin
      case (o)
        3'd1: begin n = m_t; b = m_n; tag = "R5"; end
        3'd2: begin t = m_n; n = m_t; tag = "R6"; end
        3'd3: begin t = m_n; n = m_b; b = m_t; tag = "R7"; end
        3'd4: begin t = (m_t % 16'h0100) * 16'h0100 + m_t / 16'h0100; tag = "R8"; end
        3'd5: begin t = mirror(m_t); tag = "R9"; end
        default: tag = "R10";
      endcase
    end
    ld_en = l; byte_mode = bm; op = o; ld_data = d;
    @(negedge clk);
    chk(tag, tos, nos, bos, t, n, b);
    m_t = t; m_n = n; m_b = b;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", tos, nos, bos, 16'h0, 16'h0, 16'h0);
    rst_n = 1'b1;
    m_t = 16'h0; m_n = 16'h0; m_b = 16'h0;
    step(1'b1, 1'b0, 3'd0, 16'h1111);
    step(1'b0, 1'b0, 3'd1, 16'h0);
    step(1'b1, 1'b0, 3'd0, 16'h2222);
    step(1'b0, 1'b0, 3'd1, 16'h0);
    step(1'b1, 1'b0, 3'd0, 16'h3333);
    step(1'b1, 1'b1, 3'd0, 16'hABCD);
    step(1'b0, 1'b0, 3'd3, 16'h0);
    step(1'b0, 1'b0, 3'd3, 16'h0);
    step(1'b0, 1'b0, 3'd3, 16'h0);
    step(1'b1, 1'b0, 3'd0, 16'h8001);
    step(1'b0, 1'b0, 3'd5, 16'h0);
    step(1'b1, 1'b0, 3'd0, 16'h12F0);
    step(1'b0, 1'b1, 3'd4, 16'h0);
    step(1'b0, 1'b0, 3'd5, 16'h0);
    for (int rep = 0; rep < 40; rep++)
      for (int o = 0; o < 8; o++)
        for (int l = 0; l < 2; l++)
          for (int bm = 0; bm < 2; bm++)
            step(l[0], bm[0], o[2:0], 16'($urandom));
    ld_en = 1'b0; op = 3'd3;
    rst_n = 1'b0;
    #1;
    chk("R1", tos, nos, bos, 16'h0, 16'h0, 16'h0);
    @(negedge clk);
    chk("R1", tos, nos, bos, 16'h0, 16'h0, 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule